// File: doc/BRIEF.md
# Frame-Aligned Video Pixel Sink

This block terminates a packetised video stream and hands its pixels to a slower consumer. Beats arrive on a valid/ready handshake and carry packet start and packet end markers. The first beat of every packet is a header whose low four bits give the packet type. Only image packets are kept. Control and other packets are consumed and thrown away. Every image pixel is stored, in arrival order, in a deep internal FIFO together with one bit that marks the first pixel of a frame.

The consumer drains the FIFO through a show-ahead read port. The head entry is visible whenever the empty flag is low, and a read strobe removes it. The FIFO's fullness is the only source of input back-pressure. A producer that runs ahead of the consumer is therefore stalled between pixels, at any point in a frame, and no pixel is lost. Frames arrive in raster order, top-left first and bottom-right last, so the frame-start bit alone lets the consumer realign to the image.

Top module: `vsink_frame_sink`

## Requirements
- R1: After reset, `rd_empty` is 1 and `in_ready` is 1.
- R2: A beat is accepted when `in_valid` and `in_ready` are both 1. An accepted beat with `in_sop`=1 is a header and is never stored. Its `in_data[3:0]`=0 opens an image packet, and the upper header bits play no part in this.
- R3: The first pixel stored after an image header has its frame-start bit at 1. Every other stored pixel has it at 0.
- R4: A packet whose header has `in_data[3:0]` other than 0 stores nothing, up to and including its end-of-packet beat.
- R5: Beats accepted outside any packet are discarded. This covers beats before the first header after reset and beats between an end-of-packet and the next header.
- R6: `in_ready` is 0 exactly when the FIFO holds DEPTH entries. The same rule applies while a non-image packet is being dropped.
- R7: Stored pixels come out in arrival order. When `rd_empty` is 0, `rd_pixel` and `rd_frame_start` show the oldest entry, and `rd_en`=1 removes it at the clock edge.
- R8: `rd_en`=1 while `rd_empty` is 1 has no effect.
- R9: While `in_ready` is 0, a beat held on the input is not accepted. It is taken unchanged once space appears.
- R10: A header that arrives before the current packet's end-of-packet beat ends that packet and starts a new one according to its own type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted (FIFO not full) |
| in_sop | input | 1 | Beat is the first of a packet (header) |
| in_eop | input | 1 | Beat is the last of a packet |
| in_data | input | 16 | Header type in bits 3:0, or one pixel |
| rd_en | input | 1 | Remove the head entry |
| rd_empty | output | 1 | FIFO holds no entry |
| rd_pixel | output | 16 | Pixel of the head entry |
| rd_frame_start | output | 1 | Head entry is the first pixel of a frame |

## Verification
The bench builds the block with DEPTH=16. At that depth a single image packet can fill the FIFO in a few dozen cycles. This brings the full-boundary back-pressure, stalls held in the middle of a frame, and the release of those stalls into easy reach. A reference queue tracks the FIFO's contents every cycle while the consumer switches between idle, always-read and pseudo-random reading, so reads against an empty FIFO also occur. The default depth of 1024 is only elaborated.

// File: rtl/vsink_pkg.sv
package vsink_pkg;

    localparam int PIX_W      = 16;
    localparam int TYPE_W     = 4;
    localparam logic [TYPE_W-1:0] IMAGE_TYPE = '0;

    typedef struct packed {
        logic             sof;
        logic [PIX_W-1:0] pix;
    } vs_entry_t;

    localparam int ENTRY_W = $bits(vs_entry_t);

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_IMAGE = 2'd1,
        PS_DROP  = 2'd2
    } ps_state_t;

    function automatic logic is_image_hdr(input logic [PIX_W-1:0] hdr);
        return hdr[TYPE_W-1:0] == IMAGE_TYPE;
    endfunction

endpackage

// File: rtl/vsink_pkt_filter.sv
module vsink_pkt_filter
    import vsink_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             beat_fire,
    input  logic             beat_sop,
    input  logic             beat_eop,
    input  logic [PIX_W-1:0] beat_data,
    output logic             wr_en,
    output vs_entry_t        wr_entry
);

    ps_state_t state_q, state_d;
    logic      pend_q, pend_d;

    // Pixel beats of an open image packet are stored; headers never are.
    always_comb begin
        wr_en        = beat_fire && !beat_sop && (state_q == PS_IMAGE);
        wr_entry.sof = pend_q;
        wr_entry.pix = beat_data;
    end

    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        if (beat_fire) begin
            if (beat_sop) begin
                if (is_image_hdr(beat_data)) begin
                    state_d = PS_IMAGE;
                    pend_d  = 1'b1;
                end else begin
                    state_d = PS_DROP;
                end
                if (beat_eop) state_d = PS_IDLE;
            end else begin
                if (state_q == PS_IMAGE) pend_d = 1'b0;
                if (beat_eop) state_d = PS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    // A header never produces a store in the same beat
    assert_no_header_store_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (beat_fire && !beat_sop));

    // A frame start needs a header in between, so two adjacent flagged stores are impossible
    assert_single_sof_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_entry.sof) |=> !(wr_en && wr_entry.sof));

    // The beat after a non-image header never stores
    assert_drop_after_ctrl_R4: assert property (@(posedge clk) disable iff (rst)
        (beat_fire && beat_sop && !is_image_hdr(beat_data)) |=> !wr_en);

endmodule

// File: rtl/vsink_fifo.sv
module vsink_fifo
    import vsink_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  vs_entry_t push_entry,
    input  logic      pop_req,
    output vs_entry_t head_entry,
    output logic      empty,
    output logic      full
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [AW-1:0]      wptr_q, rptr_q;
    logic [CW-1:0]      count_q;
    logic               pop;

    always_comb begin
        empty      = (count_q == '0);
        full       = (count_q == CW'(DEPTH));
        pop        = pop_req && !empty;
        head_entry = vs_entry_t'(mem[rptr_q]);
    end

    always_ff @(posedge clk) begin
        if (push) mem[wptr_q] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) wptr_q <= wptr_q + AW'(1);
            if (pop)  rptr_q <= rptr_q + AW'(1);
            case ({push, pop})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    assert_pop_shrinks_R7: assert property (@(posedge clk) disable iff (rst)
        (pop && !push) |=> (count_q == $past(count_q) - CW'(1)));

    assert_empty_read_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (pop_req && empty && !push) |=> empty);

    assert_push_fills_R7: assert property (@(posedge clk) disable iff (rst)
        (push && !pop_req) |=> !empty);

endmodule

// File: rtl/vsink_frame_sink.sv
module vsink_frame_sink
    import vsink_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [15:0] in_data,
    input  logic        rd_en,
    output logic        rd_empty,
    output logic [15:0] rd_pixel,
    output logic        rd_frame_start
);

    logic      fifo_full;
    logic      fifo_empty;
    logic      beat_fire;
    logic      wr_en;
    vs_entry_t wr_entry;
    vs_entry_t head;

    assign in_ready  = !fifo_full;
    assign beat_fire = in_valid && in_ready;

    vsink_pkt_filter u_filter (
        .clk       (clk),
        .rst       (rst),
        .beat_fire (beat_fire),
        .beat_sop  (in_sop),
        .beat_eop  (in_eop),
        .beat_data (in_data),
        .wr_en     (wr_en),
        .wr_entry  (wr_entry)
    );

    vsink_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push       (wr_en),
        .push_entry (wr_entry),
        .pop_req    (rd_en),
        .head_entry (head),
        .empty      (fifo_empty),
        .full       (fifo_full)
    );

    assign rd_empty       = fifo_empty;
    assign rd_pixel       = head.pix;
    assign rd_frame_start = head.sof;

    // A stalled beat that stays offered stays unaccepted until space appears
    assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready && !rd_en) |=> !in_ready);

endmodule

// File: tb/test_vsink_frame_sink.sv
module test_vsink_frame_sink;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_sop = 1'b0;
    logic        in_eop = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic        rd_empty;
    logic [15:0] rd_pixel;
    logic        rd_frame_start;
    logic        rd_en;
    logic        man_rd = 1'b0;
    int          rd_mode = 0;          // 0 idle, 1 always, 2 pseudo-random
    logic [7:0]  lfsr = 8'h5a;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;            // 200 MHz

    assign rd_en = (rd_mode == 1) || (rd_mode == 2 && lfsr[0]) || man_rd;

    vsink_frame_sink #(.DEPTH(DEPTH)) i_vsink_frame_sink (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data), .rd_en(rd_en),
        .rd_empty(rd_empty), .rd_pixel(rd_pixel), .rd_frame_start(rd_frame_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: queue of {sof, pixel}, packet state as integers
    logic [16:0] q[$];
    int  m_state = 0;                  // 0 outside, 1 image, 2 dropping
    bit  m_pend = 0;

    always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); m_state = 0; m_pend = 0;
        end else begin
            bit m_ready;
            m_ready = (q.size() < DEPTH);
            if (rd_en && q.size() > 0) void'(q.pop_front());
            if (in_valid && m_ready) begin
                if (in_sop) begin
                    if (in_data[3:0] == 4'd0) begin m_state = 1; m_pend = 1; end
                    else m_state = 2;
                    if (in_eop) m_state = 0;
                end else begin
                    if (m_state == 1) begin q.push_back({m_pend, in_data}); m_pend = 0; end
                    if (in_eop) m_state = 0;
                end
            end
        end
    end

    // Cycle-by-cycle comparison, sampled mid-period
    always @(negedge clk) begin
        if (!rst) begin
            check(in_ready == (q.size() < DEPTH), "R6 ready", in_ready, q.size() < DEPTH);
            check(rd_empty == (q.size() == 0), "R7/R8 empty", rd_empty, q.size() == 0);
            if (q.size() > 0 && !rd_empty)
                check({rd_frame_start, rd_pixel} == q[0], "R3/R7 head",
                      {rd_frame_start, rd_pixel}, q[0]);
        end
    end

    task automatic send_beat(input bit sop, input bit eop, input logic [15:0] d);
        in_valid = 1'b1; in_sop = sop; in_eop = eop; in_data = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    endtask

    task automatic send_pkt(input logic [15:0] hdr, input int n, input logic [15:0] base);
        send_beat(1'b1, n == 0, hdr);
        for (int i = 0; i < n; i++) send_beat(1'b0, i == n - 1, base + 16'(i));
    endtask

    task automatic pop_one();
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
    endtask

    task automatic drain();
        rd_mode = 1;
        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        rd_mode = 0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(rd_empty == 1'b1, "R1 empty", rd_empty, 1);
        check(in_ready == 1'b1, "R1 ready", in_ready, 1);

        // R5: beats before any header are discarded
        for (int i = 0; i < 3; i++) send_beat(1'b0, i == 2, 16'h0100 + 16'(i));
        repeat (2) @(negedge clk);
        check(rd_empty == 1'b1, "R5 stray beats", rd_empty, 1);

        // R4: control packet with payload is dropped
        send_pkt(16'h0003, 4, 16'h0200);
        repeat (2) @(negedge clk);
        check(rd_empty == 1'b1, "R4 control dropped", rd_empty, 1);

        // R2, R3: image header stored as nothing; first pixel flagged
        send_pkt(16'hFFF0, 3, 16'hA001);
        @(negedge clk);
        check(rd_pixel == 16'hA001, "R2 first stored is pixel", rd_pixel, 16'hA001);
        check(rd_frame_start == 1'b1, "R3 first flagged", rd_frame_start, 1);
        pop_one();
        check(rd_frame_start == 1'b0, "R3 second unflagged", rd_frame_start, 0);
        pop_one();
        pop_one();
        check(rd_empty == 1'b1, "R7 drained", rd_empty, 1);
        // R8: reading an empty FIFO
        pop_one(); pop_one();
        check(rd_empty == 1'b1, "R8 empty read", rd_empty, 1);

        // R5: beats between packets discarded
        send_beat(1'b0, 1'b0, 16'h0BAD);
        @(negedge clk);
        check(rd_empty == 1'b1, "R5 between packets", rd_empty, 1);

        // R6, R9: fill with the consumer idle, stall, then release
        fork
            send_pkt(16'h0000, 24, 16'hC000);
            begin
                repeat (40) @(negedge clk);
                check(in_ready == 1'b0, "R6 full", in_ready, 0);
                check(in_valid == 1'b1, "R9 beat held", in_valid, 1);
                check(rd_pixel == 16'hC000, "R9 head intact", rd_pixel, 16'hC000);
                rd_mode = 2;
            end
        join
        drain();

        // R6: ready stays high while dropping when not full
        rd_mode = 2;
        send_pkt(16'h0007, 6, 16'h0300);
        check(q.size() == 0, "R4 nothing queued", q.size(), 0);
        drain();

        // R10: header before end-of-packet restarts the parse
        send_beat(1'b1, 1'b0, 16'h0000);
        send_beat(1'b0, 1'b0, 16'hD000);
        send_beat(1'b0, 1'b0, 16'hD001);
        send_beat(1'b1, 1'b0, 16'h0000);
        send_beat(1'b0, 1'b0, 16'hD100);
        send_beat(1'b0, 1'b1, 16'hD101);
        send_beat(1'b1, 1'b0, 16'h0005);   // control interrupts, then image restarts
        send_beat(1'b0, 1'b0, 16'h0EEE);
        send_beat(1'b1, 1'b0, 16'h0000);
        send_beat(1'b0, 1'b1, 16'hD200);
        @(negedge clk);
        check(rd_frame_start == 1'b1 && rd_pixel == 16'hD000, "R10 frame A", rd_pixel, 16'hD000);
        pop_one(); pop_one();
        check(rd_frame_start == 1'b1 && rd_pixel == 16'hD100, "R10 frame B", rd_pixel, 16'hD100);
        pop_one(); pop_one();
        check(rd_frame_start == 1'b1 && rd_pixel == 16'hD200, "R10 frame C", rd_pixel, 16'hD200);
        pop_one();
        check(rd_empty == 1'b1, "R10 no control payload", rd_empty, 1);

        // Mixed traffic with a random consumer
        rd_mode = 2;
        for (int f = 0; f < 6; f++) begin
            send_pkt(16'h0001, 2, 16'h0400);
            send_pkt(16'h0000, 20 + f, 16'(f * 256));
        end
        drain();
        check(rd_empty == 1'b1, "R7 final drain", rd_empty, 1);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule